// File: doc/BRIEF.md
# Bus Tenure Timeout Monitor

This block sits beside a system bus arbiter and watches how long each address tenure and each data tenure stays open. Each phase has its own timer. A timer starts when a tenure-start strobe arrives and stops when the matching tenure-end strobe arrives. If a tenure is still open when its programmed limit runs out, the block latches a timeout flag for that phase. The same flag register also captures single-cycle pulses that report a slave transfer error and a transaction with a reserved transfer type.

Software programs both limits through one 32-bit limit register. Each limit counts in units of 128 bus clocks. Software reads the flags from an event register and clears any flag by writing a one to its bit. An interrupt line stays high while any flag is set. The register port is a single write strobe with a one-bit register select. Read data is combinational and shows the currently selected register.

Top module: `tenure_timeout_monitor`

## Requirements
- R1: After reset, both registers read as zero and `irq` is low.
- R2: A write with `reg_sel`=0 loads all 32 bits of the limit register. Bits 31:16 hold the data-phase limit and bits 15:0 hold the address-phase limit. The limit register reads back unchanged with `reg_sel`=0.
- R3: Let the address limit be n, with n nonzero. If an address tenure opens at clock edge E and does not end, `event_flags[0]` is still 0 after edge E+128n-1 and is 1 after edge E+128n.
- R4: Let the data limit be n, with n nonzero. If a data tenure opens at clock edge E and does not end, `event_flags[1]` is still 0 after edge E+128n-1 and is 1 after edge E+128n.
- R5: If a tenure ends before its limit, no timeout flag is raised for it. A new start strobe restarts the count from zero.
- R6: A limit value of zero disables that timer. A tenure of any length then raises no flag.
- R7: A pulse on `xfer_err` sets `event_flags[5]` at the next clock edge. A pulse on `rsvd_type` sets `event_flags[4]` at the next clock edge.
- R8: With `reg_sel`=1, the read data shows the flags in bits 5:0 and zeros in bits 31:6. Bits 3 and 2 have no source in this block and always read zero. Written bits 31:6 have no effect.
- R9: A write with `reg_sel`=1 clears each flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R10: If a hardware set and a write-one clear reach the same flag in the same cycle, the flag ends up set.
- R11: `irq` is high exactly when at least one flag is set.
- R12: Each timed-out tenure raises its flag only once. If software clears the flag while that tenure is still open, the flag stays clear until a new tenure of that phase times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 = limit register, 1 = event register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| addr_start | input | 1 | Address tenure start strobe |
| addr_end | input | 1 | Address tenure end strobe |
| data_start | input | 1 | Data tenure start strobe |
| data_end | input | 1 | Data tenure end strobe |
| xfer_err | input | 1 | Slave transfer-error pulse |
| rsvd_type | input | 1 | Reserved-transfer-type pulse |
| event_flags | output | 6 | Latched flags: 5 transfer error, 4 reserved type, 3:2 unused, 1 data timeout, 0 address timeout |
| irq | output | 1 | Interrupt, high while any flag is set |

## Verification
The assertions assume that a start strobe and an end strobe for the same phase never arrive in the same cycle. They also assume that a limit is not reprogrammed while a tenure of that phase is open. In either case the expiry cycle would depend on the order of the two events. The stimulus drives strobes only as isolated one-cycle pulses and changes the limit register only while both tenures are closed. The only deliberate overlap is the same-cycle set and clear on the transfer-error flag. It is there to exercise the priority rule.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int unsigned FLAG_N = 6;

    localparam int unsigned F_ALATE = 0;
    localparam int unsigned F_DLATE = 1;
    localparam int unsigned F_SPARE0 = 2;
    localparam int unsigned F_SPARE1 = 3;
    localparam int unsigned F_RSVD  = 4;
    localparam int unsigned F_TERR  = 5;

    typedef enum logic {
        SEL_LIMIT = 1'b0,
        SEL_EVENT = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/tmon_tenure_timer.sv
module tmon_tenure_timer #(
    parameter int unsigned LIMIT_W = 16,
    parameter int unsigned PRE_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               open_i,
    input  logic               close_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               expire_o
);

    typedef struct packed {
        logic               busy;
        logic               done;
        logic [PRE_W-1:0]   pre;
        logic [LIMIT_W-1:0] cnt;
    } tstate_t;

    tstate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (open_i) begin
            st_d      = '0;
            st_d.busy = 1'b1;
        end else if (close_i) begin
            st_d = '0;
        end else if (st_q.busy && !st_q.done) begin
            st_d.pre = st_q.pre + 1'b1;
            if (&st_q.pre) begin
                st_d.cnt = st_q.cnt + 1'b1;
                if ((limit_i != '0) && (st_d.cnt >= limit_i)) begin
                    expire_o  = 1'b1;
                    st_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tmon_limit_reg.sv
module tmon_limit_reg #(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] value_o
);

    typedef struct packed {
        logic [REG_W-1:0] val;
    } lstate_t;

    lstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.val = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.val;

endmodule

// File: rtl/tmon_event_reg.sv
module tmon_event_reg #(
    parameter int unsigned FLAG_N = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] set_i,
    input  logic [FLAG_N-1:0] clr_i,
    output logic [FLAG_N-1:0] flags_o
);

    typedef struct packed {
        logic [FLAG_N-1:0] flags;
    } estate_t;

    estate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < int'(FLAG_N); i++) begin
            if (set_i[i]) begin
                st_d.flags[i] = 1'b1;
            end else if (clr_i[i]) begin
                st_d.flags[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/tenure_timeout_monitor.sv
module tenure_timeout_monitor
    import tmon_pkg::*;
#(
    parameter int unsigned LIMIT_W = 16,
    parameter int unsigned PRE_W   = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr_en,
    input  logic                   reg_sel,
    input  logic [2*LIMIT_W-1:0]   reg_wdata,
    output logic [2*LIMIT_W-1:0]   reg_rdata,
    input  logic                   addr_start,
    input  logic                   addr_end,
    input  logic                   data_start,
    input  logic                   data_end,
    input  logic                   xfer_err,
    input  logic                   rsvd_type,
    output logic [FLAG_N-1:0]      event_flags,
    output logic                   irq
);

    localparam int unsigned REG_W  = 2 * LIMIT_W;
    localparam int unsigned TMR_N  = 2;

    logic [REG_W-1:0]   limit_q;
    logic [TMR_N-1:0]   t_open, t_close, t_exp;
    logic [LIMIT_W-1:0] t_lim [TMR_N];
    logic [FLAG_N-1:0]  set_vec, clr_vec;
    logic               lim_we;

    // Timer 0 watches the address phase, timer 1 the data phase.
    assign t_open  = {data_start, addr_start};
    assign t_close = {data_end, addr_end};
    assign lim_we  = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_LIMIT);

    tmon_limit_reg #(.REG_W(REG_W)) i_limit (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (lim_we),
        .wdata_i (reg_wdata),
        .value_o (limit_q)
    );

    generate
        for (genvar g = 0; g < int'(TMR_N); g++) begin : g_timer
            assign t_lim[g] = limit_q[g*LIMIT_W +: LIMIT_W];
            tmon_tenure_timer #(.LIMIT_W(LIMIT_W), .PRE_W(PRE_W)) i_timer (
                .clk      (clk),
                .rst_n    (rst_n),
                .open_i   (t_open[g]),
                .close_i  (t_close[g]),
                .limit_i  (t_lim[g]),
                .expire_o (t_exp[g])
            );
        end
    endgenerate

    always_comb begin
        set_vec           = '0;
        set_vec[F_ALATE]  = t_exp[0];
        set_vec[F_DLATE]  = t_exp[1];
        set_vec[F_RSVD]   = rsvd_type;
        set_vec[F_TERR]   = xfer_err;
        clr_vec           = '0;
        if (reg_wr_en && (reg_sel_e'(reg_sel) == SEL_EVENT)) begin
            clr_vec = reg_wdata[FLAG_N-1:0];
        end
    end

    tmon_event_reg #(.FLAG_N(FLAG_N)) i_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .flags_o (event_flags)
    );

    always_comb begin
        if (reg_sel_e'(reg_sel) == SEL_EVENT) begin
            reg_rdata = {{(REG_W-FLAG_N){1'b0}}, event_flags};
        end else begin
            reg_rdata = limit_q;
        end
    end

    assign irq = |event_flags;

endmodule

// File: rtl/tmon_checker.sv
module tmon_checker #(
    parameter int unsigned LIMIT_W = 16,
    parameter int unsigned FLAG_N  = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr_en,
    input logic                 reg_sel,
    input logic [2*LIMIT_W-1:0] reg_wdata,
    input logic                 addr_start,
    input logic                 addr_end,
    input logic                 data_start,
    input logic                 data_end,
    input logic                 xfer_err,
    input logic                 rsvd_type,
    input logic [FLAG_N-1:0]    event_flags,
    input logic                 irq
);

    assert_terr_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> event_flags[5]);

    assert_rsvd_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_type |=> event_flags[4]);

    assert_aend_no_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_end && !addr_start) |=> !$rose(event_flags[0]));

    assert_dend_no_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_end && !data_start) |=> !$rose(event_flags[1]));

    assert_irq_fall_on_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr_en && reg_sel));

    generate
        for (genvar b = 0; b < int'(FLAG_N); b++) begin : g_hold
            assert_flag_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (event_flags[b] && !(reg_wr_en && reg_sel && reg_wdata[b])) |=> event_flags[b]);
        end
    endgenerate

endmodule

bind tenure_timeout_monitor tmon_checker #(.LIMIT_W(LIMIT_W), .FLAG_N(6)) i_tmon_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .addr_start  (addr_start),
    .addr_end    (addr_end),
    .data_start  (data_start),
    .data_end    (data_end),
    .xfer_err    (xfer_err),
    .rsvd_type   (rsvd_type),
    .event_flags (event_flags),
    .irq         (irq)
);

// File: tb/test_tenure_timeout_monitor.sv
`timescale 1ns/1ps
module test_tenure_timeout_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        addr_start = 1'b0, addr_end = 1'b0;
    logic        data_start = 1'b0, data_end = 1'b0;
    logic        xfer_err = 1'b0, rsvd_type = 1'b0;
    logic [5:0]  event_flags;
    logic        irq;

    always #5 clk = ~clk;

    tenure_timeout_monitor i_tenure_timeout_monitor (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .addr_start(addr_start), .addr_end(addr_end),
        .data_start(data_start), .data_end(data_end),
        .xfer_err(xfer_err), .rsvd_type(rsvd_type),
        .event_flags(event_flags), .irq(irq)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    // Behavioural reference model
    logic [31:0] m_lim;
    logic [5:0]  m_flags;
    int          m_age  [2];
    bit          m_open [2];
    bit          m_fired[2];
    bit          m_st   [2];
    bit          m_en   [2];
    logic [1:0]  m_fire;
    logic [5:0]  m_clr;
    int          m_limv;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lim   = '0;
            m_flags = '0;
            for (int t = 0; t < 2; t++) begin
                m_age[t] = 0; m_open[t] = 0; m_fired[t] = 0;
            end
        end else begin
            m_st[0] = addr_start; m_en[0] = addr_end;
            m_st[1] = data_start; m_en[1] = data_end;
            m_fire  = '0;
            for (int t = 0; t < 2; t++) begin
                m_limv = (t == 0) ? int'(m_lim[15:0]) : int'(m_lim[31:16]);
                if (m_st[t]) begin
                    m_open[t] = 1; m_age[t] = 0; m_fired[t] = 0;
                end else if (m_en[t]) begin
                    m_open[t] = 0; m_age[t] = 0; m_fired[t] = 0;
                end else if (m_open[t] && !m_fired[t]) begin
                    m_age[t]++;
                    if (m_limv != 0 && m_age[t] >= 128 * m_limv) begin
                        m_fire[t]  = 1'b1;
                        m_fired[t] = 1;
                    end
                end
            end
            m_clr   = (reg_wr_en && reg_sel) ? reg_wdata[5:0] : 6'h0;
            m_flags = (m_flags & ~m_clr) | {xfer_err, rsvd_type, 2'b00, m_fire};
            if (reg_wr_en && !reg_sel) m_lim = reg_wdata;
        end
    end

    // Per-cycle comparison, sampled well after the edge
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            check(cur_req, {26'h0, event_flags}, {26'h0, m_flags}, "model flags");
            check("R11", {31'h0, irq}, {31'h0, |m_flags}, "model irq");
            check(cur_req, reg_rdata, reg_sel ? {26'h0, m_flags} : m_lim, "model rdata");
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // v = {xfer_err, rsvd_type, data_end, data_start, addr_end, addr_start}
    task automatic strobe(input logic [5:0] v);
        {xfer_err, rsvd_type, data_end, data_start, addr_end, addr_start} = v;
        @(negedge clk);
        {xfer_err, rsvd_type, data_end, data_start, addr_end, addr_start} = '0;
    endtask

    task automatic reg_write(input logic sel, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1: reset state
        cur_req = "R1";
        reg_sel = 1'b0;
        @(negedge clk);
        check("R1", reg_rdata, 32'h0, "limit after reset");
        reg_sel = 1'b1;
        @(negedge clk);
        check("R1", reg_rdata, 32'h0, "events after reset");
        check("R1", {31'h0, irq}, 32'h0, "irq after reset");

        // R2: limit layout, data=3 address=2
        cur_req = "R2";
        reg_write(1'b0, 32'h0003_0002);
        check("R2", reg_rdata, 32'h0003_0002, "limit readback");

        // R3: address timeout at exactly 256 edges
        cur_req = "R3";
        reg_sel = 1'b1;
        strobe(6'b000001);
        wait_n(255);
        check("R3", {31'h0, event_flags[0]}, 32'h0, "addr flag one edge early");
        wait_n(1);
        check("R3", {31'h0, event_flags[0]}, 32'h1, "addr flag at limit");
        check("R11", {31'h0, irq}, 32'h1, "irq with addr flag");

        // R12: cleared flag not re-raised in the same tenure
        cur_req = "R12";
        reg_write(1'b1, 32'h1);
        check("R12", {31'h0, event_flags[0]}, 32'h0, "addr flag cleared");
        wait_n(300);
        check("R12", {31'h0, event_flags[0]}, 32'h0, "no second expiry");
        strobe(6'b000010);

        // R5: data tenure ends before 384 edges
        cur_req = "R5";
        strobe(6'b000100);
        wait_n(300);
        strobe(6'b001000);
        wait_n(200);
        check("R5", {31'h0, event_flags[1]}, 32'h0, "no data flag after early end");

        // R4: data timeout at exactly 384 edges
        cur_req = "R4";
        strobe(6'b000100);
        wait_n(383);
        check("R4", {31'h0, event_flags[1]}, 32'h0, "data flag one edge early");
        wait_n(1);
        check("R4", {31'h0, event_flags[1]}, 32'h1, "data flag at limit");
        strobe(6'b001000);
        reg_write(1'b1, 32'h2);

        // R6: zero address limit disables the timer
        cur_req = "R6";
        reg_write(1'b0, 32'h0003_0000);
        check("R6", reg_rdata, 32'h0003_0000, "limit with zero address field");
        reg_sel = 1'b1;
        strobe(6'b000001);
        wait_n(600);
        check("R6", {31'h0, event_flags[0]}, 32'h0, "disabled timer stays quiet");
        strobe(6'b000010);

        // R7: error pulses
        cur_req = "R7";
        strobe(6'b100000);
        check("R7", {31'h0, event_flags[5]}, 32'h1, "transfer error flag");
        strobe(6'b010000);
        check("R7", {31'h0, event_flags[4]}, 32'h1, "reserved type flag");

        // R8: event register layout, upper bits ignored
        cur_req = "R8";
        check("R8", reg_rdata, 32'h0000_0030, "event readback");
        reg_write(1'b1, 32'hFFFF_FFC0);
        check("R8", reg_rdata, 32'h0000_0030, "upper write bits ignored");

        // R9: write-one-to-clear
        cur_req = "R9";
        reg_write(1'b1, 32'h10);
        check("R9", reg_rdata, 32'h0000_0020, "clear only bit 4");
        reg_write(1'b1, 32'h0);
        check("R9", reg_rdata, 32'h0000_0020, "zero write keeps flags");

        // R10: set wins over same-cycle clear
        cur_req = "R10";
        reg_write(1'b1, 32'h20);
        check("R10", reg_rdata, 32'h0, "flag cleared first");
        reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h20; xfer_err = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0; xfer_err = 1'b0;
        check("R10", reg_rdata, 32'h0000_0020, "set beats clear");

        // R11: irq drops when all flags clear
        cur_req = "R11";
        check("R11", {31'h0, irq}, 32'h1, "irq high");
        reg_write(1'b1, 32'h3F);
        check("R11", {31'h0, irq}, 32'h0, "irq low after clear");
        check("R11", {26'h0, event_flags}, 32'h0, "all flags clear");

        wait_n(2);
        finish_run();
    end

endmodule